// File: doc/BRIEF.md
# Thermal Window Status Tracker

This block watches a stream of signed temperature conversions and keeps three
status flags: one for readings that have fallen under a lower bound, one for
readings above an upper bound, and one for readings above a critical bound. A
single hysteresis amount is shared by all three bounds. It makes each flag
release only once the reading has moved back past its bound by that amount.
The release point sits below the bound for the upper and critical flags and
above it for the lower flag. An optional qualifier, turned on by an input,
holds back the setting of a flag until a run of consecutive qualifying
conversions has been seen. Releasing a flag is never held back.

A conversion counts only in a cycle where the sample strobe is high and the
shutdown input is low. In every other cycle the flags keep their value. Each
flag drives a one-cycle change pulse on every set and on every release, so a
downstream interrupt controller can run in either a level style or an edge
style. The setpoints are plain inputs. The package holds their power-on codes
for the integration to tie or load: hysteresis 0x020, lower 0x0A0, upper
0x400, critical 0x500.

Each flag is a small state machine with three states. `FS_IDLE` means the flag
is clear and no run is being counted. `FS_ARM` means the flag is clear and a
run of qualifying conversions is in progress; it is used only with the
qualifier on. `FS_SET` means the flag is raised. The transitions are:
- idle-to-set: a qualifying conversion arrives with the qualifier off, or it completes the run.
- idle-to-arm: a qualifying conversion arrives with the qualifier on and the run is not yet complete.
- arm-to-arm: a further qualifying conversion arrives and the run is still incomplete.
- arm-to-set: the run completes.
- arm-to-idle: a conversion arrives that does not qualify.
- set-to-idle: a conversion arrives beyond the release point.

Top module: `thermwin_status`

## Requirements
- R1: After reset, `flags_o` and `chg_o` are all zero. The bit positions of both ports are: bit 0 for the lower flag, bit 1 for the upper flag and bit 2 for the critical flag.
- R2: The upper flag sets on a conversion whose sample is strictly greater than `high_i`. The new value appears on `flags_o` in the cycle after the conversion. A sample equal to `high_i` does not set it.
- R3: Once set, the upper flag clears only on a conversion whose sample is strictly less than `high_i - hyst_i`. A sample equal to that point, or between that point and the bound, leaves the flag set.
- R4: The critical flag sets on a sample strictly greater than `crit_i`. It clears only on a sample strictly less than `crit_i - hyst_i`.
- R5: The lower flag sets on a sample strictly less than `low_i`. It clears only on a sample strictly greater than `low_i + hyst_i`.
- R6: With `fq_en_i` high, a flag sets only on the fourth consecutive qualifying conversion. Any conversion that does not qualify restarts the count from zero. Cycles without a conversion do not break the run.
- R7: Clearing is not filtered. With `fq_en_i` high, a set flag still clears on the first conversion beyond its release point.
- R8: While `shdn_i` is high, samples are ignored, even with the strobe high. The flags hold and no change pulse is issued.
- R9: In cycles where `samp_vld_i` is low, the flags hold and `chg_o` is zero.
- R10: `chg_o[k]` is high for exactly one cycle, in the same cycle as each set or clear of flag k, and low at all other times.
- R11: The release points are computed with 14 bits, so they do not wrap. With `low_i` = 0x0FFF and `hyst_i` = 0x020, a set lower flag stays set for every sample. With `high_i` = 0x1000 and `hyst_i` = 0x020, a set upper flag stays set for every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_i | input | 13 | Temperature sample, two's complement, 0.0625 °C per LSB |
| samp_vld_i | input | 1 | The sample is a new conversion in this cycle |
| hyst_i | input | 13 | Hysteresis amount, same code |
| low_i | input | 13 | Lower window bound |
| high_i | input | 13 | Upper window bound |
| crit_i | input | 13 | Critical bound |
| fq_en_i | input | 1 | Turns on the consecutive-conversion qualifier |
| shdn_i | input | 1 | Shutdown: conversions are ignored |
| flags_o | output | 3 | Status flags: {critical, upper, lower} |
| chg_o | output | 3 | One-cycle change pulse for each flag |

## Verification
The assertions assume that the hysteresis amount is not negative and that the
setpoints stay steady over any run of qualifying conversions. The stimulus
holds the setpoints fixed for blocks of several hundred cycles and draws the
hysteresis only from non-negative codes. It also keeps the bounds apart by
more than twice the hysteresis, so the release ranges of the lower and upper
flags never overlap. Random samples are drawn near whichever bound is under
test, with the strobe, the shutdown input and the qualifier switched at
random. Directed steps land exactly on each bound, on each release point, and
on the extreme codes.

// File: rtl/thermwin_pkg.sv
package thermwin_pkg;
    localparam int TW_W  = 13;
    localparam int EXT_W = TW_W + 1;
    localparam int NFLAG = 3;

    localparam int FLG_LOW  = 0;
    localparam int FLG_HIGH = 1;
    localparam int FLG_CRIT = 2;

    localparam logic [TW_W-1:0] RST_HYST = 13'h0020;
    localparam logic [TW_W-1:0] RST_LOW  = 13'h00A0;
    localparam logic [TW_W-1:0] RST_HIGH = 13'h0400;
    localparam logic [TW_W-1:0] RST_CRIT = 13'h0500;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ARM  = 2'd1,
        FS_SET  = 2'd2
    } flag_st_e;
endpackage

// File: rtl/thermwin_thresh.sv
module thermwin_thresh
    import thermwin_pkg::*;
#(
    parameter int W  = TW_W,
    parameter int EW = W + 1,
    parameter int NF = NFLAG
) (
    input  logic [W-1:0]           samp_i,
    input  logic [W-1:0]           hyst_i,
    input  logic [W-1:0]           low_i,
    input  logic [W-1:0]           high_i,
    input  logic [W-1:0]           crit_i,
    output logic [EW-1:0]          samp_x_o,
    output logic [NF-1:0][EW-1:0]  lim_o,
    output logic [NF-1:0][EW-1:0]  rel_o
);
    logic signed [EW-1:0] hyst_x;
    logic signed [EW-1:0] low_x;
    logic signed [EW-1:0] high_x;
    logic signed [EW-1:0] crit_x;

    // Widen by one bit so that bound +/- hysteresis cannot wrap.
    always_comb begin
        hyst_x   = {{(EW-W){hyst_i[W-1]}}, hyst_i};
        low_x    = {{(EW-W){low_i[W-1]}},  low_i};
        high_x   = {{(EW-W){high_i[W-1]}}, high_i};
        crit_x   = {{(EW-W){crit_i[W-1]}}, crit_i};
        samp_x_o = {{(EW-W){samp_i[W-1]}}, samp_i};

        lim_o           = '0;
        rel_o           = '0;
        lim_o[FLG_LOW]  = low_x;
        rel_o[FLG_LOW]  = low_x + hyst_x;
        lim_o[FLG_HIGH] = high_x;
        rel_o[FLG_HIGH] = high_x - hyst_x;
        lim_o[FLG_CRIT] = crit_x;
        rel_o[FLG_CRIT] = crit_x - hyst_x;
    end
endmodule

// File: rtl/thermwin_flag.sv
module thermwin_flag
    import thermwin_pkg::*;
#(
    parameter bit LOW_SIDE = 1'b0,
    parameter int DEPTH    = 4,
    parameter int EW       = EXT_W,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_i,
    input  logic                 fq_en_i,
    input  logic signed [EW-1:0] samp_i,
    input  logic signed [EW-1:0] lim_i,
    input  logic signed [EW-1:0] rel_i,
    output logic                 flag_o,
    output logic                 chg_o
);
    flag_st_e        st_q, st_n;
    logic [CW-1:0]   cnt_q, cnt_n, cnt_inc;
    logic            hit_w, rel_w;
    logic            flag_q, chg_q;

    // The compare direction depends on which side of the window the flag guards.
    generate
        if (LOW_SIDE) begin : g_low
            assign hit_w = samp_i < lim_i;
            assign rel_w = samp_i > rel_i;
        end else begin : g_high
            assign hit_w = samp_i > lim_i;
            assign rel_w = samp_i < rel_i;
        end
    endgenerate

    assign cnt_inc = cnt_q + CW'(1);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (conv_i) begin
            unique case (st_q)
                FS_IDLE, FS_ARM: begin
                    if (hit_w) begin
                        if (!fq_en_i || (cnt_inc >= CW'(DEPTH))) begin
                            st_n  = FS_SET;
                            cnt_n = '0;
                        end else begin
                            st_n  = FS_ARM;
                            cnt_n = cnt_inc;
                        end
                    end else begin
                        st_n  = FS_IDLE;
                        cnt_n = '0;
                    end
                end
                FS_SET: begin
                    if (rel_w) begin
                        st_n = FS_IDLE;
                    end
                    cnt_n = '0;
                end
                default: begin
                    st_n  = FS_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            chg_q  <= 1'b0;
        end else begin
            flag_q <= (st_n == FS_SET);
            chg_q  <= (st_n == FS_SET) != (st_q == FS_SET);
        end
    end

    assign flag_o = flag_q;
    assign chg_o  = chg_q;

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_i |=> ($stable(flag_q) && !chg_q));

    // R2
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(conv_i) && $past(hit_w)));

    // R3
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> ($past(conv_i) && $past(rel_w)));

    // R10
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_q) |-> chg_q);

    // R10
    pulse_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> !$stable(flag_q));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(DEPTH));

    generate
        if (DEPTH > 1) begin : g_qchk
            // R6
            queued_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(flag_q) && $past(fq_en_i)) |-> ($past(st_q) == FS_ARM));
        end
    endgenerate
endmodule

// File: rtl/thermwin_status.sv
module thermwin_status
    import thermwin_pkg::*;
#(
    parameter int W     = TW_W,
    parameter int DEPTH = 4,
    localparam int EW   = W + 1,
    localparam int NF   = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  samp_i,
    input  logic          samp_vld_i,
    input  logic [W-1:0]  hyst_i,
    input  logic [W-1:0]  low_i,
    input  logic [W-1:0]  high_i,
    input  logic [W-1:0]  crit_i,
    input  logic          fq_en_i,
    input  logic          shdn_i,
    output logic [NF-1:0] flags_o,
    output logic [NF-1:0] chg_o
);
    logic                 conv_w;
    logic [EW-1:0]        samp_x;
    logic [NF-1:0][EW-1:0] lim_v;
    logic [NF-1:0][EW-1:0] rel_v;

    assign conv_w = samp_vld_i && !shdn_i;

    thermwin_thresh #(.W(W), .EW(EW), .NF(NF)) thresh_i (
        .samp_i   (samp_i),
        .hyst_i   (hyst_i),
        .low_i    (low_i),
        .high_i   (high_i),
        .crit_i   (crit_i),
        .samp_x_o (samp_x),
        .lim_o    (lim_v),
        .rel_o    (rel_v)
    );

    generate
        for (genvar k = 0; k < NF; k++) begin : g_flag
            thermwin_flag #(
                .LOW_SIDE (k == FLG_LOW),
                .DEPTH    (DEPTH),
                .EW       (EW)
            ) flag_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .conv_i  (conv_w),
                .fq_en_i (fq_en_i),
                .samp_i  (samp_x),
                .lim_i   (lim_v[k]),
                .rel_i   (rel_v[k]),
                .flag_o  (flags_o[k]),
                .chg_o   (chg_o[k])
            );
        end
    endgenerate

    // R9
    no_conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld_i |=> (chg_o == '0));
endmodule

// File: tb/thermwin_status_tb_top.sv
module thermwin_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] samp = '0;
    logic        vld = 1'b0;
    logic [12:0] hyst = 13'h020, low = 13'h0A0, high = 13'h400, crit = 13'h500;
    logic        fq = 1'b0;
    logic        shdn = 1'b0;
    logic [2:0]  flags, chg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit       m_flag [3];
    int       m_cnt  [3];
    bit [2:0] m_chg;

    always #4 clk = ~clk;

    thermwin_status dut_i (
        .clk(clk), .rst_n(rst_n), .samp_i(samp), .samp_vld_i(vld),
        .hyst_i(hyst), .low_i(low), .high_i(high), .crit_i(crit),
        .fq_en_i(fq), .shdn_i(shdn), .flags_o(flags), .chg_o(chg)
    );

    function automatic int sx(logic [12:0] v);
        return int'($signed(v));
    endfunction

    // Reference update for one clock edge, written from the requirements.
    function automatic void model_step();
        int s, b, h;
        bit hit, rls;
        m_chg = '0;
        if (!(vld && !shdn)) return;
        s = sx(samp);
        h = sx(hyst);
        for (int k = 0; k < 3; k++) begin
            b   = (k == 0) ? sx(low) : (k == 1) ? sx(high) : sx(crit);
            hit = (k == 0) ? (s < b) : (s > b);
            rls = (k == 0) ? (s > b + h) : (s < b - h);
            if (m_flag[k]) begin
                if (rls) begin m_flag[k] = 1'b0; m_chg[k] = 1'b1; end
            end else if (hit) begin
                m_cnt[k]++;
                if (!fq || m_cnt[k] >= 4) begin
                    m_flag[k] = 1'b1; m_chg[k] = 1'b1; m_cnt[k] = 0;
                end
            end else begin
                m_cnt[k] = 0;
            end
        end
    endfunction

    task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge, compare at the next one.
    task automatic cyc(string tag, bit v, logic [12:0] s);
        vld  = v;
        samp = s;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " flags"}, flags, {m_flag[2], m_flag[1], m_flag[0]});
        check({tag, " chg"}, chg, m_chg);
    endtask

    initial begin
        void'($urandom(32'd7715));
        for (int k = 0; k < 3; k++) begin m_flag[k] = 1'b0; m_cnt[k] = 0; end
        repeat (3) @(negedge clk);
        check("R1 reset flags", flags, 3'b000);
        check("R1 reset chg", chg, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        cyc("R2 equal bound", 1, 13'h400);
        check("R2 equal no set", flags, 3'b000);
        cyc("R2 above bound", 1, 13'h401);
        check("R2 set", flags, 3'b010);
        check("R10 set pulse", chg, 3'b010);
        cyc("R10 idle", 0, 13'h000);
        check("R10 pulse one cycle", chg, 3'b000);
        cyc("R3 at release", 1, 13'h3E0);
        check("R3 hold", flags, 3'b010);
        cyc("R3 below release", 1, 13'h3DF);
        check("R3 clear", flags, 3'b000);
        check("R10 clear pulse", chg, 3'b010);
        cyc("R4 crit set", 1, 13'h501);
        check("R4 crit and high", flags, 3'b110);
        cyc("R4 crit hold", 1, 13'h4E0);
        check("R4 hold", flags, 3'b110);
        cyc("R4 crit clear", 1, 13'h4DF);
        check("R4 clear", flags, 3'b010);
        cyc("R3 drop", 1, 13'h100);
        cyc("R5 low set", 1, 13'h09F);
        check("R5 set", flags, 3'b001);
        cyc("R5 low hold", 1, 13'h0C0);
        check("R5 hold", flags, 3'b001);
        cyc("R5 low clear", 1, 13'h0C1);
        check("R5 clear", flags, 3'b000);
        shdn = 1'b1;
        cyc("R8 shutdown", 1, 13'h600);
        check("R8 ignored", flags, 3'b000);
        shdn = 1'b0;
        cyc("R9 no strobe", 0, 13'h600);
        check("R9 ignored", flags, 3'b000);
        fq = 1'b1;
        cyc("R6 q1", 1, 13'h410);
        cyc("R6 q2", 1, 13'h410);
        cyc("R6 gap", 0, 13'h000);
        cyc("R6 q3", 1, 13'h410);
        check("R6 not yet", flags, 3'b000);
        cyc("R6 break", 1, 13'h3F0);
        cyc("R6 r1", 1, 13'h410);
        cyc("R6 r2", 1, 13'h410);
        cyc("R6 r3", 1, 13'h410);
        check("R6 restart holds", flags, 3'b000);
        cyc("R6 r4", 1, 13'h410);
        check("R6 fourth sets", flags, 3'b010);
        cyc("R7 clear", 1, 13'h100);
        check("R7 immediate clear", flags, 3'b000);
        fq = 1'b0;
        low = 13'h0FFF;
        cyc("R11 low set", 1, 13'h0FFE);
        cyc("R11 low max", 1, 13'h0FFF);
        check("R11 low no wrap", flags[0], 1'b1);
        low = 13'h1000;
        cyc("R11 low reset", 1, 13'h0000);
        high = 13'h1000;
        crit = 13'h0FFF;
        cyc("R11 high set", 1, 13'h1001);
        cyc("R11 high min", 1, 13'h1000);
        check("R11 high no wrap", flags[1], 1'b1);

        // Random phase: blocks of fixed setpoints.
        for (int blk = 0; blk < 20; blk++) begin
            int lo, hg, cr, hy, pick, ctr;
            hy   = $urandom_range(0, 64);
            lo   = $urandom_range(0, 600) - 300;
            hg   = lo + 2 * hy + 1 + $urandom_range(0, 300);
            cr   = hg + $urandom_range(0, 300);
            hyst = 13'(hy); low = 13'(lo); high = 13'(hg); crit = 13'(cr);
            fq   = $urandom_range(0, 1);
            for (int i = 0; i < 300; i++) begin
                pick = $urandom_range(0, 2);
                ctr  = (pick == 0) ? lo : (pick == 1) ? hg : cr;
                shdn = ($urandom_range(0, 19) == 0);
                cyc("R10 random", ($urandom_range(0, 4) != 0),
                    13'(ctr + $urandom_range(0, 2 * hy + 20) - hy - 10));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule